// File: doc/BRIEF.md
# SPI Master Frame Engine with Counted Chip Select

This block is the shifting core of an SPI master. It takes words from a transmit queue and sends each one as a frame of 1 to 32 bits. It uses SPI mode 0 and sends the most significant bit first. Each received frame is handed to a receive queue. The register decode and the queue storage are outside the block. The block sees the queues only through a valid/pop strobe on the transmit side and a one-cycle write strobe on the receive side.

A single active-low chip select is driven by the block itself. A 16-bit batch counter sets how many frames make up one batch. In held mode, chip select stays low from the first frame of a batch to the last. In pulsed mode, chip select rises after every frame. When the batch counter runs out, the block does three things: it raises chip select, reloads the counter from the configured batch length, and emits a pair of completion events. These events are a transmit-complete event and a receive-ready event, and each has a sticky flag. Both flags clear when the next frame starts.

The frame width is held in a register inside the block. Software writes it through a strobe, and the write is accepted only while the engine is disabled and only for legal widths. A synchronous soft reset puts the engine back to its power-on state.

Top module: `spi_fc_master`

## Requirements
- R1: After reset (or before the first frame), `cs_n` is 1, `sclk` is 0, `done_flag`, `rdy_flag`, `rx_wr` and `tx_pop` are 0. The frame width is 4 bits. The remaining batch count is 1, so the first frame after reset completes a batch.
- R2: A frame starts only when `enable` is 1, `tx_valid` is 1 and the remaining batch count is non-zero. Each frame asserts `tx_pop` for exactly one cycle, and that pop consumes `tx_data`.
- R3: In mode 0, `sclk` idles at 0 and stays 0 whenever `cs_n` is 1. Each half period of `sclk` within a frame lasts `clk_div`+1 clock cycles. `mosi` carries bit (width-1) of the transmit word first and bit 0 last, so the word is right-aligned and its upper bits are not sent.
- R4: `miso` is sampled on each rising `sclk`. When a frame ends, `rx_wr` pulses for one cycle. At that pulse, `rx_data` holds the received bits right-aligned (first bit received in bit width-1), and all bits above the frame width are 0.
- R5: When `sustain` is 0, `cs_n` returns to 1 after every frame, for at least one cycle before the next frame.
- R6: When `sustain` is 1, `cs_n` stays 0 between the frames of a batch. It returns to 1 only when the batch count runs out.
- R7: When the remaining count goes from 1 to 0 at the end of a frame, several things happen in the same cycle: `done_evt` and `rdy_evt` pulse, `done_flag` and `rdy_flag` set, and `cs_n` goes to 1. The count also reloads from `frame_count`.
- R8: The start of every frame clears `done_flag` and `rdy_flag`. The clear is visible in the same cycle that `cs_n` goes to 0.
- R9: A `size_wr` strobe loads `size_val` into the frame width only if `enable` is 0 and `size_val` is between 1 and 32. Any other write leaves the width unchanged.
- R10: A `cfg_load` strobe sets the remaining batch count to `frame_count`.
- R11: A `soft_rst` strobe returns the engine to the R1 state, including width 4 and remaining count 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to the reset state |
| enable | input | 1 | Engine enable |
| sustain | input | 1 | 1: hold chip select across a batch; 0: pulse it per frame |
| frame_count | input | 16 | Batch length used on load and on reload |
| cfg_load | input | 1 | Load the remaining count from frame_count |
| size_wr | input | 1 | Frame width write strobe |
| size_val | input | 6 | Frame width written by size_wr |
| clk_div | input | 8 | sclk half period minus one, in clock cycles |
| tx_valid | input | 1 | Transmit queue not empty |
| tx_data | input | 32 | Head word of the transmit queue |
| tx_pop | output | 1 | Consume the head transmit word |
| rx_wr | output | 1 | Receive word valid, one cycle |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| done_evt | output | 1 | Transmit-complete event pulse |
| rdy_evt | output | 1 | Receive-ready event pulse |
| done_flag | output | 1 | Transmit-complete status |
| rdy_flag | output | 1 | Receive-ready status |

## Verification
The hardest state to reach is a batch that stalls partway through. In that state the transmit queue runs dry while the remaining count is still non-zero, and no completion event may fire. The stimulus loads a batch of five frames but queues only two words. It then checks that chip select has gone high with no event. Next it disables the engine and queues more words, and checks that no pop happens. Only after re-enabling does it expect the event, after the last three frames. A separate sequence shortens a batch in flight with a fresh load. This tells a reloaded counter apart from a stale one, because only the reloaded count completes after a single further frame.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } fc_state_e;

  localparam int unsigned RESET_WIDTH = 4;

endpackage

// File: rtl/spi_fc_tick.sv
module spi_fc_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_n  = cnt_q;
    cnt_en = 1'b1;
    if (!run || clr) begin
      cnt_n = '0;
    end else if (cnt_q == div) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign tick = run && !clr && (cnt_q == div);

endmodule

// File: rtl/spi_fc_shift.sv
module spi_fc_shift #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              rise,
  input  logic              fall,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word,
  output logic              last_bit
);

  localparam logic [SIZE_W-1:0] FULL = SIZE_W'(DATA_W);

  logic [DATA_W-1:0] tx_q, tx_n;
  logic [DATA_W-1:0] rx_q, rx_n;
  logic [SIZE_W-1:0] left_q, left_n;
  logic              sh_en;

  always_comb begin
    tx_n   = tx_q;
    rx_n   = rx_q;
    left_n = left_q;
    sh_en  = 1'b0;
    if (load) begin
      tx_n   = tx_word << (FULL - size);
      rx_n   = '0;
      left_n = size;
      sh_en  = 1'b1;
    end else if (rise) begin
      rx_n   = {rx_q[DATA_W-2:0], miso};
      left_n = left_q - 1'b1;
      sh_en  = 1'b1;
    end else if (fall && (left_q != '0)) begin
      tx_n   = {tx_q[DATA_W-2:0], 1'b0};
      sh_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      left_q <= '0;
    end else if (sh_en) begin
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      left_q <= left_n;
    end
  end

  assign mosi     = tx_q[DATA_W-1];
  assign rx_word  = rx_q;
  assign last_bit = (left_q == '0);

endmodule

// File: rtl/spi_fc_frmctr.sv
module spi_fc_frmctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             load_cfg,
  input  logic [CNT_W-1:0] cfg_val,
  input  logic             dec,
  output logic             zero,
  output logic             exhaust
);

  logic [CNT_W-1:0] rem_q, rem_n;
  logic             rem_en;

  assign exhaust = dec && (rem_q == CNT_W'(1));
  assign zero    = (rem_q == '0);

  always_comb begin
    rem_n  = rem_q;
    rem_en = 1'b1;
    if (soft_clr) begin
      rem_n = CNT_W'(1);
    end else if (load_cfg) begin
      rem_n = cfg_val;
    end else if (exhaust) begin
      rem_n = cfg_val;
    end else if (dec && !zero) begin
      rem_n = rem_q - 1'b1;
    end else begin
      rem_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= CNT_W'(1);
    end else if (rem_en) begin
      rem_q <= rem_n;
    end
  end

endmodule

// File: rtl/spi_fc_master.sv
module spi_fc_master
  import spi_fc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8,
  parameter int SIZE_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              enable,
  input  logic              sustain,
  input  logic [CNT_W-1:0]  frame_count,
  input  logic              cfg_load,
  input  logic              size_wr,
  input  logic [SIZE_W-1:0] size_val,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_wr,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  output logic              done_evt,
  output logic              rdy_evt,
  output logic              done_flag,
  output logic              rdy_flag
);

  localparam logic [SIZE_W-1:0] MAX_SIZE = SIZE_W'(DATA_W);
  localparam logic [SIZE_W-1:0] RST_SIZE = SIZE_W'(RESET_WIDTH);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_i_n = rst_sync_q[1];

  // frame width register
  logic [SIZE_W-1:0] size_q, size_n;
  logic              size_en;

  always_comb begin
    size_n  = size_q;
    size_en = 1'b0;
    if (soft_rst) begin
      size_n  = RST_SIZE;
      size_en = 1'b1;
    end else if (size_wr && !enable && (size_val != '0) && (size_val <= MAX_SIZE)) begin
      size_n  = size_val;
      size_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      size_q <= RST_SIZE;
    end else if (size_en) begin
      size_q <= size_n;
    end
  end

  // sequencing state
  fc_state_e state_q, state_n;
  logic      sclk_q, sclk_n;
  logic      cs_n_q, cs_n_n;
  logic      dflag_q, dflag_n;
  logic      rflag_q, rflag_n;
  logic      devt_q, devt_n;
  logic      revt_q, revt_n;
  logic      rxwr_q, rxwr_n;

  logic tick, rise, fall, last_bit, frame_end;
  logic rem_zero, exhaust, start, running;

  assign running   = (state_q == ST_SHIFT);
  assign start     = (state_q == ST_IDLE) && enable && tx_valid && !rem_zero && !soft_rst;
  assign rise      = running && tick && !sclk_q && !soft_rst;
  assign fall      = running && tick &&  sclk_q && !soft_rst;
  assign frame_end = fall && last_bit;

  spi_fc_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (running && !soft_rst),
    .clr   (start),
    .div   (clk_div),
    .tick  (tick)
  );

  spi_fc_shift #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (start),
    .size     (size_q),
    .tx_word  (tx_data),
    .rise     (rise),
    .fall     (fall),
    .miso     (miso),
    .mosi     (mosi),
    .rx_word  (rx_data),
    .last_bit (last_bit)
  );

  spi_fc_frmctr #(.CNT_W(CNT_W)) u_frmctr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .soft_clr (soft_rst),
    .load_cfg (cfg_load),
    .cfg_val  (frame_count),
    .dec      (frame_end),
    .zero     (rem_zero),
    .exhaust  (exhaust)
  );

  always_comb begin
    state_n = state_q;
    sclk_n  = sclk_q;
    cs_n_n  = cs_n_q;
    dflag_n = dflag_q;
    rflag_n = rflag_q;
    devt_n  = 1'b0;
    revt_n  = 1'b0;
    rxwr_n  = 1'b0;
    if (soft_rst) begin
      state_n = ST_IDLE;
      sclk_n  = 1'b0;
      cs_n_n  = 1'b1;
      dflag_n = 1'b0;
      rflag_n = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_n = ST_SHIFT;
            cs_n_n  = 1'b0;
            dflag_n = 1'b0;
            rflag_n = 1'b0;
          end else if (!enable) begin
            cs_n_n  = 1'b1;
          end
        end
        ST_SHIFT: begin
          if (rise) begin
            sclk_n = 1'b1;
          end else if (fall) begin
            sclk_n = 1'b0;
            if (last_bit) begin
              state_n = ST_IDLE;
              rxwr_n  = 1'b1;
              if (exhaust || !sustain) begin
                cs_n_n = 1'b1;
              end
              if (exhaust) begin
                devt_n  = 1'b1;
                revt_n  = 1'b1;
                dflag_n = 1'b1;
                rflag_n = 1'b1;
              end
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      dflag_q <= 1'b0;
      rflag_q <= 1'b0;
      devt_q  <= 1'b0;
      revt_q  <= 1'b0;
      rxwr_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      sclk_q  <= sclk_n;
      cs_n_q  <= cs_n_n;
      dflag_q <= dflag_n;
      rflag_q <= rflag_n;
      devt_q  <= devt_n;
      revt_q  <= revt_n;
      rxwr_q  <= rxwr_n;
    end
  end

  assign tx_pop    = start;
  assign rx_wr     = rxwr_q;
  assign sclk      = sclk_q;
  assign cs_n      = cs_n_q;
  assign done_evt  = devt_q;
  assign rdy_evt   = revt_q;
  assign done_flag = dflag_q;
  assign rdy_flag  = rflag_q;

endmodule

// File: rtl/spi_fc_checker.sv
module spi_fc_checker #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              enable,
  input logic              sustain,
  input logic              tx_valid,
  input logic              tx_pop,
  input logic              rx_wr,
  input logic              sclk,
  input logic              cs_n,
  input logic              done_evt,
  input logic              rdy_evt,
  input logic              done_flag,
  input logic              rdy_flag,
  input logic [SIZE_W-1:0] size_q
);

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_pop_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (enable && tx_valid));

  p_rx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr |=> !rx_wr);

  p_pulse_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr && $past(!sustain && !soft_rst)) |-> cs_n);

  p_done_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (cs_n && done_flag && rdy_flag && rdy_evt));

  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && !soft_rst) |=> (!done_flag && !rdy_flag && !cs_n));

  p_size_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable && !soft_rst) |-> $stable(size_q));

  p_size_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q != '0) && (size_q <= SIZE_W'(DATA_W)));

endmodule

bind spi_fc_master spi_fc_checker #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .enable    (enable),
  .sustain   (sustain),
  .tx_valid  (tx_valid),
  .tx_pop    (tx_pop),
  .rx_wr     (rx_wr),
  .sclk      (sclk),
  .cs_n      (cs_n),
  .done_evt  (done_evt),
  .rdy_evt   (rdy_evt),
  .done_flag (done_flag),
  .rdy_flag  (rdy_flag),
  .size_q    (size_q)
);

// File: tb/spi_fc_master_bench.sv
module spi_fc_master_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst, enable, sustain, cfg_load, size_wr;
  logic [15:0] frame_count;
  logic [5:0]  size_val;
  logic [7:0]  clk_div;
  logic        tx_valid, tx_pop, rx_wr, sclk, mosi, miso, cs_n;
  logic        done_evt, rdy_evt, done_flag, rdy_flag;
  logic [31:0] tx_data, rx_data;

  always #10 clk = ~clk;

  // transmit queue model
  logic [31:0] q_mem [0:63];
  int          q_head = 0;
  int          q_tail = 0;
  assign tx_valid = (q_head != q_tail);
  assign tx_data  = q_mem[q_head[5:0]];
  always @(posedge clk) if (tx_pop) q_head <= q_head + 1;

  spi_fc_master u_spi_fc_master (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
    .sustain(sustain), .frame_count(frame_count), .cfg_load(cfg_load),
    .size_wr(size_wr), .size_val(size_val), .clk_div(clk_div),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_wr(rx_wr), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .done_evt(done_evt), .rdy_evt(rdy_evt),
    .done_flag(done_flag), .rdy_flag(rdy_flag)
  );

  int n_chk  = 0;
  int n_fail = 0;

  function automatic logic [31:0] pat(input int idx);
    return (32'(idx + 1) * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] msk(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  // serial monitor and slave model
  int          cyc = 0, frames_seen = 0, k = 0, cur_size = 4, halfp = 3;
  int          cs_rises = 0, done_cnt = 0, rdy_cnt = 0, bad_half = 0, idle_bad = 0;
  int          last_chg = 0;
  bit          have_last = 0;
  logic        prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [31:0] cap = '0;
  logic [31:0] fr_mosi [0:63];
  logic [31:0] fr_rx   [0:63];
  int          fr_bits [0:63];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cs_n && sclk) idle_bad++;
      if (sclk && !prev_sclk) begin
        cap = {cap[30:0], mosi};
        k++;
      end
      if (sclk != prev_sclk) begin
        if (have_last && (cyc - last_chg != halfp)) bad_half++;
        last_chg  = cyc;
        have_last = 1;
      end
      if (rx_wr) begin
        fr_mosi[frames_seen[5:0]] = cap;
        fr_rx[frames_seen[5:0]]   = rx_data;
        fr_bits[frames_seen[5:0]] = k;
        frames_seen++;
        k = 0; cap = '0; have_last = 0;
      end
      if (cs_n && !prev_cs) cs_rises++;
      if (done_evt) done_cnt++;
      if (rdy_evt) rdy_cnt++;
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
    if (k < cur_size) begin
      logic [31:0] p;
      p = pat(frames_seen);
      miso = p[cur_size-1-k];
    end else begin
      miso = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic push(input logic [31:0] w);
    q_mem[q_tail[5:0]] = w;
    q_tail = q_tail + 1;
  endtask

  task automatic wait_frames(input int target, input string tag);
    int guard = 0;
    while (frames_seen < target && guard < 20000) begin
      step();
      guard++;
    end
    chk(frames_seen >= target, tag, frames_seen, target);
    step(4);
  endtask

  task automatic strobe_load(input logic [15:0] cnt);
    frame_count = cnt;
    cfg_load = 1'b1; step(); cfg_load = 1'b0;
  endtask

  task automatic write_size(input logic [5:0] v);
    size_val = v;
    size_wr = 1'b1; step(); size_wr = 1'b0;
  endtask

  task automatic check_frame(input int idx, input int w, input logic [31:0] word, input string tag);
    chk(fr_bits[idx] == w, {tag, " bit count"}, fr_bits[idx], w);
    chk(fr_mosi[idx] == (word & msk(w)), {tag, " mosi word"}, fr_mosi[idx], word & msk(w));
    chk(fr_rx[idx] == (pat(idx) & msk(w)), {tag, " rx word"}, fr_rx[idx], pat(idx) & msk(w));
  endtask

  task automatic t_reset_state;
    chk(cs_n == 1'b1, "R1 cs_n idle", cs_n, 1);
    chk(sclk == 1'b0, "R1 sclk idle", sclk, 0);
    chk({done_flag, rdy_flag} == 2'b00, "R1 flags clear", {done_flag, rdy_flag}, 0);
    chk({rx_wr, tx_pop} == 2'b00, "R1 strobes low", {rx_wr, tx_pop}, 0);
    // default width 4, remaining count 1
    cur_size = 4; halfp = 3;
    enable = 1'b1;
    push(32'h0000_00A5);
    wait_frames(1, "R1 first frame");
    check_frame(0, 4, 32'h0000_00A5, "R1");
    chk(done_cnt == 1, "R1 single frame completes batch", done_cnt, 1);
    chk(done_flag && rdy_flag, "R7 flags set", {done_flag, rdy_flag}, 3);
  endtask

  task automatic t_pulsed_batch;
    int f0 = frames_seen, c0 = cs_rises, d0 = done_cnt, r0 = rdy_cnt;
    enable = 1'b0; step();
    write_size(6'd8); clk_div = 8'd1; halfp = 2; cur_size = 8; sustain = 1'b0;
    strobe_load(16'd3);
    enable = 1'b1;
    push(32'h0000_01C3); push(32'h0000_02A5); push(32'h0000_035A);
    wait_frames(f0 + 3, "R2 pulsed batch progress");
    check_frame(f0, 8, 32'h0000_01C3, "R3 R4 frame0");
    check_frame(f0 + 1, 8, 32'h0000_02A5, "R3 R4 frame1");
    check_frame(f0 + 2, 8, 32'h0000_035A, "R3 R4 frame2");
    chk(cs_rises - c0 == 3, "R5 cs rises once per frame", cs_rises - c0, 3);
    chk(done_cnt - d0 == 1, "R7 one done event", done_cnt - d0, 1);
    chk(rdy_cnt - r0 == 1, "R7 one rdy event", rdy_cnt - r0, 1);
    chk(q_head == q_tail, "R2 one pop per frame", q_head, q_tail);
  endtask

  task automatic t_held_batch;
    int f0 = frames_seen, c0 = cs_rises, d0 = done_cnt;
    enable = 1'b0; step();
    write_size(6'd32); clk_div = 8'd0; halfp = 1; cur_size = 32; sustain = 1'b1;
    strobe_load(16'd4);
    enable = 1'b1;
    push(32'h8123_4567); push(32'h0F0F_F0F0); push(32'hDEAD_BEEF); push(32'h0000_0001);
    wait_frames(f0 + 4, "R6 held batch progress");
    check_frame(f0, 32, 32'h8123_4567, "R6 frame0");
    check_frame(f0 + 3, 32, 32'h0000_0001, "R6 frame3");
    chk(cs_rises - c0 == 1, "R6 cs held across batch", cs_rises - c0, 1);
    chk(done_cnt - d0 == 1, "R7 held batch done", done_cnt - d0, 1);
    chk(cs_n == 1'b1, "R7 cs high after batch", cs_n, 1);
  endtask

  task automatic t_stalled_batch;
    int f0 = frames_seen, c0 = cs_rises, d0 = done_cnt, h0;
    enable = 1'b0; step();
    write_size(6'd8); clk_div = 8'd2; halfp = 3; cur_size = 8; sustain = 1'b0;
    strobe_load(16'd5);
    enable = 1'b1;
    push(32'h11); push(32'h22);
    wait_frames(f0 + 2, "R2 stalled batch progress");
    step(30);
    chk(frames_seen == f0 + 2, "R2 no frame without data", frames_seen, f0 + 2);
    chk(done_cnt == d0, "R7 no event before count runs out", done_cnt, d0);
    chk(cs_rises - c0 == 2, "R5 cs high after stall", cs_rises - c0, 2);
    enable = 1'b0; step();
    h0 = q_head;
    push(32'h33); push(32'h44); push(32'h55);
    step(60);
    chk(q_head == h0, "R2 no pop while disabled", q_head, h0);
    chk(frames_seen == f0 + 2, "R2 no frame while disabled", frames_seen, f0 + 2);
    enable = 1'b1;
    wait_frames(f0 + 5, "R2 resumed batch progress");
    check_frame(f0 + 4, 8, 32'h55, "R4 resumed frame");
    chk(done_cnt - d0 == 1, "R7 done after fifth frame", done_cnt - d0, 1);
  endtask

  task automatic t_flag_clear;
    int guard = 0;
    int f0 = frames_seen;
    chk(done_flag && rdy_flag, "R7 flags held before next frame", {done_flag, rdy_flag}, 3);
    push(32'h66);
    while (cs_n && guard < 1000) begin step(); guard++; end
    chk({done_flag, rdy_flag} == 2'b00, "R8 flags cleared at frame start", {done_flag, rdy_flag}, 0);
    wait_frames(f0 + 1, "R8 frame progress");
  endtask

  task automatic t_width_writes;
    int f0 = frames_seen;
    enable = 1'b0; step();
    sustain = 1'b0; clk_div = 8'd4; halfp = 5;
    write_size(6'd12);
    write_size(6'd33);
    write_size(6'd0);
    strobe_load(16'd1);
    cur_size = 12;
    enable = 1'b1;
    push(32'hFFFF_FABC);
    wait_frames(f0 + 1, "R9 width frame progress");
    chk(fr_bits[f0] == 12, "R9 illegal widths rejected", fr_bits[f0], 12);
    check_frame(f0, 12, 32'hFFFF_FABC, "R3 upper bits dropped");
    write_size(6'd5);
    push(32'h0000_0987);
    wait_frames(f0 + 2, "R9 enabled write frame progress");
    chk(fr_bits[f0 + 1] == 12, "R9 write ignored while enabled", fr_bits[f0 + 1], 12);
    enable = 1'b0; step();
    write_size(6'd1); cur_size = 1;
    enable = 1'b1;
    push(32'h0000_0003);
    wait_frames(f0 + 3, "R9 width one progress");
    check_frame(f0 + 2, 1, 32'h0000_0003, "R9 width one");
  endtask

  task automatic t_reload;
    int f0 = frames_seen, d0;
    enable = 1'b0; step();
    write_size(6'd8); cur_size = 8; clk_div = 8'd1; halfp = 2;
    strobe_load(16'd3);
    enable = 1'b1;
    push(32'h77);
    wait_frames(f0 + 1, "R10 first frame");
    d0 = done_cnt;
    strobe_load(16'd1);
    push(32'h88);
    wait_frames(f0 + 2, "R10 reload frame");
    chk(done_cnt - d0 == 1, "R10 reload shortens batch", done_cnt - d0, 1);
  endtask

  task automatic t_soft_reset;
    int f0 = frames_seen, d0;
    enable = 1'b0; step();
    write_size(6'd16);
    strobe_load(16'd5);
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
    step(2);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R11 lines idle", {cs_n, sclk}, 2);
    chk({done_flag, rdy_flag} == 2'b00, "R11 flags cleared", {done_flag, rdy_flag}, 0);
    d0 = done_cnt;
    cur_size = 4;
    enable = 1'b1;
    push(32'h0000_BEE9);
    wait_frames(f0 + 1, "R11 frame progress");
    chk(fr_bits[f0] == 4, "R11 width back to four", fr_bits[f0], 4);
    chk(done_cnt - d0 == 1, "R11 count back to one", done_cnt - d0, 1);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; enable = 1'b0; sustain = 1'b0;
    cfg_load = 1'b0; size_wr = 1'b0; size_val = 6'd4;
    frame_count = 16'd3; clk_div = 8'd2; miso = 1'b0;
    step(5);
    rst_n = 1'b1;
    step(5);
    t_reset_state();
    t_pulsed_batch();
    t_held_batch();
    t_stalled_batch();
    t_flag_clear();
    t_width_writes();
    t_reload();
    t_soft_reset();
    chk(bad_half == 0, "R3 half period equals divider plus one", bad_half, 0);
    chk(idle_bad == 0, "R3 sclk low while deselected", idle_bad, 0);
    report();
    $finish;
  end

endmodule